// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address of each data beat of a double-data-rate memory burst. A burst begins when `start` is pulsed with a starting column, a length code and an ordering choice. On the next cycle the generator presents the first beat address. After that it moves to the following beat in every cycle where the data path asserts `advance`. Fixed bursts of 2, 4 or 8 beats wrap inside the aligned block of their own size. The beats follow either an incrementing order or an XOR-interleaved order. Beat counts are always even, because the data path fetches words in pairs.

A full-page burst walks the whole 256-column row in increasing order and wraps from the top column to column 0. It continues until `stop` is asserted. A full-page burst must begin on an even column. An odd starting column raises `align_err` for the whole burst, and the burst begins at the even column just below it. The block does not drive the data pins and does not issue array commands.

Top module: `burst_col_gen`

States: IDLE (no burst, `col_valid` low) and RUN (a beat address is presented). Transitions: IDLE→RUN on `start`; RUN→RUN on `start` (restart) or on any non-ending cycle; RUN→IDLE on `advance` at the last beat of a fixed burst, or on `stop` in a full-page burst.

## Requirements
- R1: A `start` pulse, accepted in either state, makes `col_valid` high on the next cycle, with `col_out` equal to the starting column. An odd full-page start is the exception and follows R7. A `start` during a burst abandons that burst and begins the new one.
- R2: With `advance` high, `col_out` moves to the next beat address one cycle later. With `advance` low, `col_out` holds. `advance` and `stop` have no effect in IDLE.
- R3: `len_sel` selects the length: 0 gives 2 beats, 1 gives 4 beats, 2 gives 8 beats. With `ilv_sel`=0, beat k of a fixed burst of length L has low bits (s + k) mod L, where s is the starting low bits. The column bits above the block do not change.
- R4: With `ilv_sel`=1 and a fixed length L, beat k has low bits s XOR k. The upper bits do not change.
- R5: `last_beat` is high only while beat L-1 of a fixed burst is presented. An `advance` in that cycle ends the burst, and `col_valid` is low on the next cycle.
- R6: `len_sel`=3 selects full page. Each advance adds one to the column modulo 256, so column 255 is followed by column 0. `ilv_sel` is ignored in this mode, and `last_beat` stays low.
- R7: A full-page start at an odd column keeps `align_err` high while that burst runs, and the first address is the column minus one. A fixed burst may start at any column, with `align_err` low.
- R8: `stop` ends a full-page burst, and `col_valid` is low on the next cycle. `stop` is ignored during a fixed burst. When inputs coincide, `start` wins over `stop`, and `stop` wins over `advance`.
- R9: After reset, `col_valid`, `last_beat` and `align_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new burst |
| start_col | input | 8 | Starting column |
| len_sel | input | 2 | 0:2, 1:4, 2:8 beats, 3:full page |
| ilv_sel | input | 1 | 1 selects interleaved order (fixed lengths) |
| advance | input | 1 | Move to the next beat |
| stop | input | 1 | End a full-page burst |
| col_out | output | 8 | Current beat column address |
| col_valid | output | 1 | A burst is running |
| last_beat | output | 1 | Final beat of a fixed burst |
| align_err | output | 1 | Full-page burst started on an odd column |

## Verification
The bench builds the block with its default 8-bit column. This means a full-page burst of a few hundred advances reaches the wrap from column 255 to 0. Directed bursts start at offsets in the middle of their blocks, so that both orderings must wrap inside the block. They start near the top of the row, so that the full-page wrap and the odd-start correction are both reached. A long random phase mixes restarts, `stop` during fixed bursts and idle gaps between advances, and compares every cycle against the behavioural model.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        LEN_2    = 2'd0,
        LEN_4    = 2'd1,
        LEN_8    = 2'd2,
        LEN_PAGE = 2'd3
    } len_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;
endpackage

// File: rtl/bcg_start_norm.sv
module bcg_start_norm #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] col_in,
    input  bcg_pkg::len_e    len,
    output logic [COL_W-1:0] col_norm,
    output logic             odd_page
);
    always_comb begin
        odd_page = (len == bcg_pkg::LEN_PAGE) && col_in[0];
        col_norm = col_in;
        if (odd_page) begin
            col_norm[0] = 1'b0;
        end
    end
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [COL_W-1:0] mask,
    input  logic             page,
    output logic [COL_W-1:0] cnt,
    output logic             at_end
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_end = !page && (cnt == mask);
endmodule

// File: rtl/bcg_addr_form.sv
module bcg_addr_form #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             use_xor,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] sum_path;
    logic [COL_W-1:0] xor_path;

    assign sum_path = base + cnt;
    assign xor_path = base ^ cnt;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask[i]) begin
                col[i] = base[i];
            end else if (use_xor) begin
                col[i] = xor_path[i];
            end else begin
                col[i] = sum_path[i];
            end
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_sel,
    input  logic             ilv_sel,
    input  logic             advance,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             last_beat,
    output logic             align_err
);
    import bcg_pkg::*;

    localparam int FIX_MAX_LOG = 3;

    state_e           state, nxt;
    len_e             len_q;
    logic             ilv_q;
    logic             err_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] norm_col;
    logic             odd_page;
    logic             at_end;
    logic             page;
    logic             step;

    bcg_start_norm #(.COL_W(COL_W)) u_norm (
        .col_in   (start_col),
        .len      (len_e'(len_sel)),
        .col_norm (norm_col),
        .odd_page (odd_page)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= LEN_2;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
            base_q <= '0;
        end else if (start) begin
            len_q  <= len_e'(len_sel);
            ilv_q  <= ilv_sel;
            err_q  <= odd_page;
            base_q <= norm_col;
        end
    end

    assign page = (len_q == LEN_PAGE);

    always_comb begin
        unique case (len_q)
            LEN_2:    mask = COL_W'(1);
            LEN_4:    mask = COL_W'(3);
            LEN_8:    mask = COL_W'((1 << FIX_MAX_LOG) - 1);
            LEN_PAGE: mask = '1;
        endcase
    end

    assign step = (state == ST_RUN) && advance && !start && !(page && stop);

    bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .step   (step),
        .mask   (mask),
        .page   (page),
        .cnt    (cnt),
        .at_end (at_end)
    );

    bcg_addr_form #(.COL_W(COL_W)) u_form (
        .base    (base_q),
        .cnt     (cnt),
        .mask    (mask),
        .use_xor (ilv_q && !page),
        .col     (col_out)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (start)                  nxt = ST_RUN;
                else if (page && stop)      nxt = ST_IDLE;
                else if (advance && at_end) nxt = ST_IDLE;
                else                        nxt = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        col_valid = (state == ST_RUN);
        last_beat = (state == ST_RUN) && at_end;
        align_err = (state == ST_RUN) && err_q;
    end
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [1:0]       len_sel,
    input logic             ilv_sel,
    input logic             advance,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             last_beat,
    input logic             align_err
);
    logic fp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     fp_q <= 1'b0;
        else if (start) fp_q <= (len_sel == 2'd3);
    end

    a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid);

    a_r2_hold_without_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !advance && !start && !stop) |=> (col_valid && $stable(col_out)));

    a_r5_last_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && advance && !start) |=> !col_valid);

    a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid);

    a_r6_page_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && fp_q && advance && !start && !stop)
        |=> (col_out == COL_W'($past(col_out) + 1'b1)));

    a_r6_page_no_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && fp_q) |-> !last_beat);

    a_r7_page_even_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_sel == 2'd3) |=> !col_out[0]);

    a_r8_stop_ends_page: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && fp_q && stop && !start) |=> !col_valid);

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (!last_beat && !align_err));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [1:0] len_sel = '0;
    logic       ilv_sel = 1'b0;
    logic       advance = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_out;
    logic       col_valid, last_beat, align_err;

    always #10 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_sel(len_sel), .ilv_sel(ilv_sel), .advance(advance), .stop(stop),
        .col_out(col_out), .col_valid(col_valid), .last_beat(last_beat),
        .align_err(align_err)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    // behavioural reference state
    bit m_v, m_fp, m_ilv, m_err;
    int m_base, m_len, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_v = 0; m_err = 0; m_fp = 0; m_cnt = 0;
        end else if (start) begin
            m_v = 1; m_cnt = 0; m_ilv = ilv_sel;
            m_fp = (len_sel == 3);
            m_len = m_fp ? 256 : (2 << len_sel);
            m_err = m_fp && start_col[0];
            m_base = m_err ? start_col - 1 : start_col;
        end else if (m_v) begin
            if (m_fp && stop) m_v = 0;
            else if (advance) begin
                if (!m_fp && m_cnt == m_len - 1) m_v = 0;
                else m_cnt++;
            end
        end
    end

    function automatic int exp_col();
        int blk, off;
        if (m_fp) return (m_base + m_cnt) % 256;
        blk = (m_base / m_len) * m_len;
        off = m_base % m_len;
        if (m_ilv) return blk + (off ^ m_cnt);
        return blk + ((off + m_cnt) % m_len);
    endfunction

    task automatic report(string req, int act, int exp);
        n_bad++;
        $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    endtask

    always @(negedge clk) begin
        if (!done) begin
            bit e_last;
            n_vec++;
            if (!rst_n) begin
                // R9: outputs quiet during and after reset
                if (col_valid || last_beat || align_err)
                    report("R9", {col_valid, last_beat, align_err}, 0);
            end else begin
                e_last = m_v && !m_fp && (m_cnt == m_len - 1);
                if (col_valid !== m_v) report("R1/R2/R5/R8 valid", col_valid, m_v);
                if (last_beat !== e_last) report("R5 last", last_beat, e_last);
                if (align_err !== (m_v && m_err)) report("R7 err", align_err, m_v && m_err);
                if (m_v && col_out !== 8'(exp_col())) begin
                    if (m_fp)       report("R6 page col", col_out, exp_col());
                    else if (m_ilv) report("R4 ilv col", col_out, exp_col());
                    else            report("R3 seq col", col_out, exp_col());
                end
            end
        end
    end

    task automatic drive(bit s, int col, int len, bit il, bit adv, bit stp);
        @(negedge clk);
        #1;
        start = s; start_col = 8'(col); len_sel = 2'(len);
        ilv_sel = il; advance = adv; stop = stp;
    endtask

    task automatic burst(int col, int len, bit il, int advs);
        drive(1, col, len, il, 0, 0);
        for (int i = 0; i < advs; i++) drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        drive(0, 0, 0, 0, 1, 1);             // R2 R8: idle inputs do nothing
        burst(8'h13, 0, 0, 2);               // R3 length 2 odd start
        burst(8'h06, 1, 0, 4);               // R3 4-beat wrap 6,7,4,5
        burst(8'h05, 1, 1, 4);               // R4 5,4,7,6
        burst(8'h2D, 2, 0, 8);               // R3 8-beat wrap
        burst(8'h2D, 2, 1, 8);               // R4 8-beat xor
        drive(1, 8'h40, 1, 0, 0, 0);         // R2 gaps between advances
        drive(0, 0, 0, 0, 1, 0);
        drive(0, 0, 0, 0, 0, 1);             // R8 stop ignored in fixed burst
        drive(0, 0, 0, 0, 1, 0);
        drive(1, 8'h77, 2, 1, 1, 1);         // R1 R8 restart wins
        for (int i = 0; i < 8; i++) drive(0, 0, 0, 0, 1, 0);
        burst(8'hFB, 3, 1, 300);             // R6 R7 wrap, odd start, ilv ignored
        drive(0, 0, 0, 0, 1, 1);             // R8 stop wins over advance
        drive(0, 0, 0, 0, 0, 0);
        burst(8'hFE, 3, 0, 5);
        drive(0, 0, 0, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3000; i++)
            drive(($urandom % 12) == 0, $urandom, $urandom, $urandom,
                  ($urandom % 3) != 0, ($urandom % 40) == 0);
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        #2 finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule